// File: doc/BRIEF.md
# Request-Gated DMA Channel Arbiter

This block decides which DMA channel moves its next element. Each channel supplies a 32-bit setup word and a count of elements still to move. The setup word holds an enable bit, a halt bit, a three-bit pacing code, and two five-bit peripheral numbers. The pacing code says whether the channel waits for its source peripheral, its destination peripheral, both, or neither. Peripheral requests come in as two 32-line vectors, one for single requests and one for burst requests. The block merges them, since it treats both kinds the same way.

At most one channel holds a grant at a time. The grant is a registered one-hot vector with a valid flag. The transfer engine returns a one-cycle done pulse when it has moved the element. The block then drops the grant and makes a fresh choice in the following cycle. The choice starts from the channel served last. That channel keeps winning while it stays eligible. When it drops out, the search moves to the next higher channel number and wraps past the top. A channel that asks for one of the unsupported pacing codes is never served, and its sticky per-channel flag is set.

Top module: `dma_grant_sched`

## Requirements
- R1: While the global enable input is 0, no new grant is issued.
- R2: A channel can be chosen only when setup bit 0 (enable) is 1 and setup bit 18 (halt) is 0.
- R3: Setup bits [13:11] hold the pacing code, bits [5:1] the source peripheral number and bits [10:6] the destination peripheral number. The codes work as follows:
  - Code 0 needs no request.
  - Code 1 needs the destination's request line.
  - Code 2 needs the source's request line.
  - Code 3 needs both request lines.
- R4: A request line counts as active when either its single-request bit or its burst-request bit is 1.
- R5: A channel whose remaining count is zero is never granted.
- R6: The search starts at the last channel served, which is channel 0 after reset. It moves upward through the channel numbers and wraps from the highest back to 0, taking the first eligible channel. The channel served last therefore keeps the grant while it remains eligible.
- R7: Only one grant is outstanding at a time. While it is outstanding, grant_oh and grant_vld hold still until xfer_done, whatever the other inputs do. grant_vld is 0 after the clock edge that samples xfer_done, and no new grant appears at that same edge.
- R8: A channel with pacing codes 4 to 7 is never granted. When such a channel is enabled and not halted while the global enable is 1, its bit in unsup_flag is set, and the bit stays set until reset.
- R9: After reset, grant_vld, grant_oh and unsup_flag are all 0.
- R10: When no grant is outstanding and some channel is eligible at a clock edge, the grant appears at that edge: one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global scheduling enable |
| chan_cfg | input | NCH*32 | Setup word per channel, channel k at bits [32k+31:32k] |
| chan_cnt | input | NCH*CNT_W | Remaining element count per channel |
| req_single | input | REQ_N | Single-request lines |
| req_burst | input | REQ_N | Burst-request lines |
| xfer_done | input | 1 | One-cycle pulse: the granted element has moved |
| grant_vld | output | 1 | A grant is outstanding |
| grant_oh | output | NCH | One-hot granted channel |
| unsup_flag | output | NCH | Sticky flag per channel for an unsupported pacing code |

## Verification
The assertions assume that xfer_done is pulsed only while grant_vld is 1. They also assume the setup words are not read as meaningful while reset is active. The stimulus changes inputs only on the falling edge. It raises xfer_done for exactly one cycle, and only once a grant has been seen. The hold check deliberately changes the granted channel's setup while its grant is outstanding, to show that the grant stays stable until done.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int CFG_W    = 32;
  localparam int B_EN     = 0;
  localparam int B_HALT   = 18;
  localparam int SRC_LO   = 1;
  localparam int DST_LO   = 6;
  localparam int PACE_LO  = 11;
  localparam int PID_W    = 5;
  localparam int PACE_W   = 3;

  typedef enum logic [PACE_W-1:0] {
    PACE_FREE = 3'd0,
    PACE_DST  = 3'd1,
    PACE_SRC  = 3'd2,
    PACE_BOTH = 3'd3
  } pace_e;
endpackage

// File: rtl/dma_chan_elig.sv
module dma_chan_elig
  import dma_sched_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REQ_N = 32
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [REQ_N-1:0] req,
  output logic             elig,
  output logic             bad_pace
);
  logic              cand;
  logic [PACE_W-1:0] pace;
  logic [PID_W-1:0]  src_id, dst_id;
  logic              src_rq, dst_rq, pace_ok;

  assign cand   = cfg[B_EN] && !cfg[B_HALT];
  assign pace   = cfg[PACE_LO +: PACE_W];
  assign src_id = cfg[SRC_LO +: PID_W];
  assign dst_id = cfg[DST_LO +: PID_W];
  assign src_rq = req[src_id];
  assign dst_rq = req[dst_id];

  always_comb begin
    case (pace)
      PACE_FREE: pace_ok = 1'b1;
      PACE_DST:  pace_ok = dst_rq;
      PACE_SRC:  pace_ok = src_rq;
      PACE_BOTH: pace_ok = src_rq && dst_rq;
      default:   pace_ok = 1'b0;
    endcase
  end

  assign bad_pace = cand && pace[PACE_W-1];
  assign elig     = cand && pace_ok && (cnt != '0);
endmodule

// File: rtl/dma_rot_pick.sv
module dma_rot_pick #(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  input  logic [IW-1:0]  start,
  output logic           any,
  output logic [IW-1:0]  idx,
  output logic [NCH-1:0] oh
);
  always_comb begin
    any = 1'b0;
    idx = start;
    for (int k = 0; k < NCH; k++) begin
      logic [IW:0] p;
      p = {1'b0, start} + (IW+1)'(k);
      if (p >= (IW+1)'(NCH)) p = p - (IW+1)'(NCH);
      if (!any && elig[p[IW-1:0]]) begin
        any = 1'b1;
        idx = p[IW-1:0];
      end
    end
    oh = any ? (NCH'(1) << idx) : '0;
  end
endmodule

// File: rtl/dma_grant_sched.sv
module dma_grant_sched
  import dma_sched_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 12,
  parameter int REQ_N = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_en,
  input  logic [NCH*CFG_W-1:0] chan_cfg,
  input  logic [NCH*CNT_W-1:0] chan_cnt,
  input  logic [REQ_N-1:0]     req_single,
  input  logic [REQ_N-1:0]     req_burst,
  input  logic                 xfer_done,
  output logic                 grant_vld,
  output logic [NCH-1:0]       grant_oh,
  output logic [NCH-1:0]       unsup_flag
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [REQ_N-1:0] req_any;
  logic [NCH-1:0]   elig_vec, bad_vec;
  logic             pick_any;
  logic [IW-1:0]    pick_idx, cur_q;
  logic [NCH-1:0]   pick_oh;

  assign req_any = req_single | req_burst;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_elig #(.CNT_W(CNT_W), .REQ_N(REQ_N)) i_elig (
      .cfg      (chan_cfg[c*CFG_W +: CFG_W]),
      .cnt      (chan_cnt[c*CNT_W +: CNT_W]),
      .req      (req_any),
      .elig     (elig_vec[c]),
      .bad_pace (bad_vec[c])
    );
  end

  dma_rot_pick #(.NCH(NCH)) i_pick (
    .elig  (elig_vec),
    .start (cur_q),
    .any   (pick_any),
    .idx   (pick_idx),
    .oh    (pick_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld  <= 1'b0;
      grant_oh   <= '0;
      cur_q      <= '0;
      unsup_flag <= '0;
    end else begin
      if (glb_en) unsup_flag <= unsup_flag | bad_vec;
      if (grant_vld) begin
        if (xfer_done) begin
          grant_vld <= 1'b0;
          grant_oh  <= '0;
        end
      end else if (glb_en && pick_any) begin
        grant_vld <= 1'b1;
        grant_oh  <= pick_oh;
        cur_q     <= pick_idx;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> $countones(grant_oh) == 1);                       // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !grant_vld |-> grant_oh == '0);                                 // R7
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !xfer_done) |=> (grant_vld && $stable(grant_oh))); // R7
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && xfer_done) |=> !grant_vld);                       // R7
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !grant_vld) |=> !grant_vld);                        // R1
  AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_vld) |-> (($past(elig_vec) & grant_oh) != '0));     // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (unsup_flag & $past(unsup_flag)) == $past(unsup_flag));         // R8
  AST_NO_BAD_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_vld) |-> (($past(bad_vec) & grant_oh) == '0));      // R8
endmodule

// File: tb/test_dma_grant_sched.sv
module test_dma_grant_sched;
  localparam int CLK_P = 10;
  localparam int NCH = 8, CNT_W = 12, REQ_N = 32;

  logic clk = 1'b0, rst = 1'b1, glb_en = 1'b0, xfer_done = 1'b0;
  logic [NCH*32-1:0]    chan_cfg = '0;
  logic [NCH*CNT_W-1:0] chan_cnt = '0;
  logic [REQ_N-1:0]     req_single = '0, req_burst = '0;
  logic                 grant_vld;
  logic [NCH-1:0]       grant_oh, unsup_flag;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_grant_sched #(.NCH(NCH), .CNT_W(CNT_W), .REQ_N(REQ_N)) i_dma_grant_sched (
    .clk(clk), .rst(rst), .glb_en(glb_en), .chan_cfg(chan_cfg),
    .chan_cnt(chan_cnt), .req_single(req_single), .req_burst(req_burst),
    .xfer_done(xfer_done), .grant_vld(grant_vld), .grant_oh(grant_oh),
    .unsup_flag(unsup_flag)
  );

  function automatic logic [31:0] mk(logic en, logic halt, logic [2:0] pace,
                                     logic [4:0] src, logic [4:0] dst);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[18] = halt; w[13:11] = pace; w[5:1] = src; w[10:6] = dst;
    return w;
  endfunction

  typedef struct packed {
    logic        glb;
    logic [2:0]  ch;
    logic [31:0] cfg;
    logic [11:0] cnt;
    logic [31:0] sreq;
    logic [31:0] breq;
    logic        exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, mk(1,0,0,0,0),   12'd5, 32'h0,        32'h0,        1'b0}, // R1
    '{1'b1, 3'd0, mk(1,0,0,0,0),   12'd5, 32'h0,        32'h0,        1'b1}, // R2
    '{1'b1, 3'd1, mk(0,0,0,0,0),   12'd5, 32'h0,        32'h0,        1'b0}, // R2
    '{1'b1, 3'd2, mk(1,1,0,0,0),   12'd5, 32'h0,        32'h0,        1'b0}, // R2
    '{1'b1, 3'd3, mk(1,0,0,0,0),   12'd0, 32'h0,        32'h0,        1'b0}, // R5
    '{1'b1, 3'd4, mk(1,0,1,3,7),   12'd1, 32'h0000_0080,32'h0,        1'b1}, // R3
    '{1'b1, 3'd4, mk(1,0,1,7,3),   12'd1, 32'h0000_0080,32'h0,        1'b0}, // R3
    '{1'b1, 3'd5, mk(1,0,2,20,2),  12'd9, 32'h0,        32'h0010_0000,1'b1}, // R4
    '{1'b1, 3'd5, mk(1,0,2,20,2),  12'd9, 32'h0000_0004,32'h0,        1'b0}, // R3
    '{1'b1, 3'd6, mk(1,0,3,1,31),  12'd2, 32'h0000_0002,32'h8000_0000,1'b1}, // R4
    '{1'b1, 3'd6, mk(1,0,3,1,31),  12'd2, 32'h0000_0002,32'h0,        1'b0}, // R3
    '{1'b1, 3'd7, mk(1,0,5,0,0),   12'd3, 32'h0,        32'h0,        1'b0}  // R8
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_ch(int ch, logic [31:0] cfg, logic [11:0] cnt);
    chan_cfg[ch*32 +: 32]       = cfg;
    chan_cnt[ch*CNT_W +: CNT_W] = cnt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; chan_cfg = '0; chan_cnt = '0; req_single = '0; req_burst = '0;
    glb_en = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // pulse done at a falling edge; grant drops at next rising edge
  task automatic finish_xfer();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R9 vld", grant_vld, 0);
    check("R9 oh", grant_oh, 0);
    check("R9 flag", unsup_flag, 0);

    // table walk: a single channel configured per vector
    for (int v = 0; v < NV; v++) begin
      chan_cfg = '0; chan_cnt = '0;
      glb_en = TBL[v].glb;
      set_ch(TBL[v].ch, TBL[v].cfg, TBL[v].cnt);
      req_single = TBL[v].sreq; req_burst = TBL[v].breq;
      @(negedge clk);
      check($sformatf("R10 vec%0d vld", v), grant_vld, TBL[v].exp);
      check($sformatf("R3 vec%0d oh", v), grant_oh,
            TBL[v].exp ? (32'd1 << TBL[v].ch) : 32'd0);
      if (grant_vld) finish_xfer();
      chan_cfg = '0; chan_cnt = '0; req_single = '0; req_burst = '0;
      @(negedge clk);
      check($sformatf("R7 vec%0d drop", v), grant_vld, 0);
    end
    check("R8 sticky flag", unsup_flag, 32'h80);

    // rotation test
    do_reset();
    glb_en = 1'b1;
    set_ch(1, mk(1,0,0,0,0), 12'd4);
    set_ch(2, mk(1,0,0,0,0), 12'd4);
    set_ch(5, mk(1,0,0,0,0), 12'd4);
    @(negedge clk);
    check("R6 first from 0", grant_oh, 32'h02);
    finish_xfer();
    check("R7 gap after done", grant_vld, 0);
    @(negedge clk);
    check("R6 stays on 1", grant_oh, 32'h02);
    set_ch(1, mk(1,0,0,0,0), 12'd0);
    finish_xfer();
    @(negedge clk);
    check("R6 moves to 2", grant_oh, 32'h04);
    set_ch(1, mk(1,0,0,0,0), 12'd4);
    set_ch(2, 32'h0, 12'd4);
    finish_xfer();
    @(negedge clk);
    check("R6 upward skips 1 picks 5", grant_oh, 32'h20);
    set_ch(5, mk(1,1,0,0,0), 12'd4);
    finish_xfer();
    @(negedge clk);
    check("R6 wrap to 1", grant_oh, 32'h02);

    // hold while outstanding, despite input changes
    set_ch(1, 32'h0, 12'd0);
    set_ch(3, mk(1,0,0,0,0), 12'd1);
    glb_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 hold vld", grant_vld, 1);
    check("R7 hold oh", grant_oh, 32'h02);
    finish_xfer();
    check("R7 released", grant_vld, 0);
    repeat (2) @(negedge clk);
    check("R1 no grant while disabled", grant_vld, 0);
    glb_en = 1'b1;
    @(negedge clk);
    check("R10 grant after enable", grant_oh, 32'h08);
    finish_xfer();

    // unsupported code sets nothing while globally disabled, sticks afterwards
    do_reset();
    set_ch(2, mk(1,0,6,0,0), 12'd1);
    repeat (2) @(negedge clk);
    check("R8 no flag when disabled", unsup_flag, 0);
    glb_en = 1'b1;
    @(negedge clk);
    check("R8 flag set", unsup_flag, 32'h04);
    check("R8 never granted", grant_vld, 0);
    set_ch(2, 32'h0, 12'd0);
    repeat (2) @(negedge clk);
    check("R8 flag sticky", unsup_flag, 32'h04);

    summary();
  end
endmodule